// File: doc/BRIEF.md
# Flag-Reporting Integer Divider

This unit sits beside the execute stage of a processor pipeline and performs a multi-cycle integer division on a 32-bit dividend. One start pulse hands it the dividend, the divisor, a signed/unsigned select, a halfword select and a flag saying whether quotient and remainder share one destination register. The current condition flags travel in with the operands, and the unit hands back a complete new flag set with the result. The division is done on magnitudes with a restoring radix-2 loop, and the signs are applied in a final fixup cycle.

The caller sees a one-cycle completion pulse carrying the quotient, the remainder, one write enable for each, and the five flags. The corner cases decide what gets written back: a zero divisor, the single signed overflow case, a zero dividend, and a shared destination. Halfword mode narrows only the divisor to its low 16 bits. The dividend always stays a full word.

Top module: `div_flag_unit`

## Requirements
- R1: A signed divide truncates toward zero, and the remainder takes the sign of the dividend: 45 / -6 gives quotient -7 and remainder 3, and -45 / 6 gives -7 and -3.
- R2: Flag vector layout is bit 0 zero (Z), bit 1 sign (S), bit 2 overflow (OV), bit 3 carry (CY), bit 4 saturation (SAT). On a written result, S equals quotient bit 31 and Z is 1 exactly when the quotient is 0. The remainder affects neither flag.
- R3: On a completion with a nonzero divisor that is not the overflow case, OV is 0, and CY and SAT equal bits 4:3 of `flags_in` as sampled at start.
- R4: With a divisor of zero (after any halfword narrowing), OV is 1 and both write enables stay low. Z, S, CY and SAT equal their `flags_in` values at start, whether those were all 0 or all 1.
- R5: A signed divide of 0x80000000 by -1 returns quotient 0x80000000 and remainder 0. It sets OV and S, clears Z, and asserts the usual write enables.
- R6: When `is_signed` is 0, both operands are treated as unsigned 32-bit values (0x40000000 / 4 = 0x10000000).
- R7: When `half_mode` is 1 and `is_signed` is 1, the divisor is bits 15:0 of `divisor`, sign-extended, so 0x0000FFFA acts as -6. The dividend stays 32 bits.
- R8: When `half_mode` is 1 and `is_signed` is 0, bits 15:0 of `divisor` are zero-extended, so 0x00010006 acts as 6.
- R9: A zero dividend with a nonzero divisor yields quotient 0, remainder 0, Z = 1 and OV = 0, with both results written.
- R10: When `same_dest` is 1, only the remainder write enable is asserted. Otherwise both are asserted.
- R11: After reset, `done`, `busy` and both write enables are 0. A start seen while idle at a rising edge produces `done` high for exactly one cycle, following the 34th rising edge counted from and including the accepting edge. `busy` is high from the accepting edge until that completion.
- R12: A start pulse while `busy` is high is ignored: it produces no completion of its own and does not alter the result in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a division, accepted only while idle |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand (only bits 15:0 in halfword mode) |
| is_signed | input | 1 | 1 = two's complement operands |
| half_mode | input | 1 | 1 = divisor narrowed to its low halfword |
| same_dest | input | 1 | 1 = quotient and remainder target one register |
| flags_in | input | 5 | Current flags {SAT, CY, OV, S, Z} |
| quot | output | 32 | Quotient, valid when `quot_we` is high |
| rem | output | 32 | Remainder, valid when `rem_we` is high |
| quot_we | output | 1 | Quotient write enable, a pulse with `done` |
| rem_we | output | 1 | Remainder write enable, a pulse with `done` |
| flags_out | output | 5 | Updated flags {SAT, CY, OV, S, Z}, valid at `done` |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Division in progress |

## Verification
Every internal fault surfaces only at the completion pulse, 33 cycles after acceptance. A mislatched sign or halfword extension shows up as a wrong quotient or remainder. A lost divide-by-zero marker shows up as write enables that fire, or as flags that no longer echo the sampled input. An iteration counter that is off by one moves `done` away from the predicted cycle, and a state machine that re-arms on a busy start raises an extra, unexpected completion. The scoreboard ties each completion to the cycle in which it is due, so a result that is correct but late is still caught.

// File: rtl/div_flag_unit.sv
module div_flag_unit #(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         is_signed,
  input  logic         half_mode,
  input  logic         same_dest,
  input  logic [4:0]   flags_in,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         quot_we,
  output logic         rem_we,
  output logic [4:0]   flags_out,
  output logic         done,
  output logic         busy
);
  localparam int CW = $clog2(W);
  localparam int FZ = 0;
  localparam int FS = 1;
  localparam int FV = 2;
  localparam int FC = 3;
  localparam int FT = 4;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic [W-1:0]  acc, qsh, dmag;
  logic          neg_q, neg_r, zero_r, ovf_r, same_r;
  logic [4:0]    flg_r;

  logic [W-1:0] dvs, amag, bmag, q_fix, r_fix;
  logic         a_neg, b_neg, ovf_in;
  logic [W:0]   trial;

  assign dvs = !half_mode ? divisor :
               is_signed  ? {{(W-HW){divisor[HW-1]}}, divisor[HW-1:0]} :
                            {{(W-HW){1'b0}}, divisor[HW-1:0]};
  assign a_neg  = is_signed & dividend[W-1];
  assign b_neg  = is_signed & dvs[W-1];
  assign amag   = a_neg ? (~dividend + 1'b1) : dividend;
  assign bmag   = b_neg ? (~dvs + 1'b1) : dvs;
  assign ovf_in = is_signed && (dividend == MOST_NEG) && (&dvs);

  assign trial = {acc, qsh[W-1]} - {1'b0, dmag};
  assign q_fix = neg_q ? (~qsh + 1'b1) : qsh;
  assign r_fix = neg_r ? (~acc + 1'b1) : acc;
  assign busy  = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      acc       <= '0;
      qsh       <= '0;
      dmag      <= '0;
      neg_q     <= 1'b0;
      neg_r     <= 1'b0;
      zero_r    <= 1'b0;
      ovf_r     <= 1'b0;
      same_r    <= 1'b0;
      flg_r     <= '0;
      quot      <= '0;
      rem       <= '0;
      quot_we   <= 1'b0;
      rem_we    <= 1'b0;
      flags_out <= '0;
      done      <= 1'b0;
    end else begin
      done    <= 1'b0;
      quot_we <= 1'b0;
      rem_we  <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          st     <= S_RUN;
          cnt    <= '0;
          acc    <= '0;
          qsh    <= amag;
          dmag   <= bmag;
          neg_q  <= a_neg ^ b_neg;
          neg_r  <= a_neg;
          zero_r <= (dvs == '0);
          ovf_r  <= ovf_in;
          same_r <= same_dest;
          flg_r  <= flags_in;
        end
        S_RUN: begin
          if (!trial[W]) begin
            acc <= trial[W-1:0];
            qsh <= {qsh[W-2:0], 1'b1};
          end else begin
            acc <= {acc[W-2:0], qsh[W-1]};
            qsh <= {qsh[W-2:0], 1'b0};
          end
          cnt <= cnt + 1'b1;
          if (cnt == CW'(W-1)) st <= S_FIX;
        end
        S_FIX: begin
          st   <= S_IDLE;
          done <= 1'b1;
          if (zero_r) begin
            flags_out     <= flg_r;
            flags_out[FV] <= 1'b1;
          end else begin
            quot          <= q_fix;
            rem           <= r_fix;
            rem_we        <= 1'b1;
            quot_we       <= !same_r;
            flags_out[FZ] <= (q_fix == '0);
            flags_out[FS] <= q_fix[W-1];
            flags_out[FV] <= ovf_r;
            flags_out[FC] <= flg_r[FC];
            flags_out[FT] <= flg_r[FT];
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  // R11
  we_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quot_we || rem_we) |-> done);

  // R10
  quot_needs_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quot_we |-> rem_we);

  // R4
  no_write_means_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rem_we) |-> flags_out[FV]);

  // R2
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && quot_we) |-> (flags_out[FZ] == (quot == '0)));

  // R2
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && quot_we) |-> (flags_out[FS] == quot[W-1]));

  // R5
  overflow_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && quot_we && flags_out[FV]) |-> (quot == MOST_NEG && rem == '0));
endmodule

// File: tb/sim_div_flag_unit.sv
module sim_div_flag_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dividend = '0, divisor = '0;
  logic        is_signed = 1'b0, half_mode = 1'b0, same_dest = 1'b0;
  logic [4:0]  flags_in = '0;
  logic [31:0] quot, rem;
  logic        quot_we, rem_we, done, busy;
  logic [4:0]  flags_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  div_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .is_signed(is_signed), .half_mode(half_mode),
    .same_dest(same_dest), .flags_in(flags_in), .quot(quot), .rem(rem),
    .quot_we(quot_we), .rem_we(rem_we), .flags_out(flags_out),
    .done(done), .busy(busy)
  );

  typedef struct {
    logic [31:0] q;
    logic [31:0] r;
    logic        qwe;
    logic        rwe;
    logic [4:0]  fl;
    int          due;
    string       req;
  } exp_t;

  exp_t sb[$];
  exp_t cur;
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R12", "unexpected done", 32'd1, 32'd0);
      end else begin
        cur = sb.pop_front();
        check(cyc == cur.due, cur.req, "done cycle", cyc, cur.due);
        check(quot_we == cur.qwe, cur.req, "quot_we", {31'd0, quot_we}, {31'd0, cur.qwe});
        check(rem_we == cur.rwe, cur.req, "rem_we", {31'd0, rem_we}, {31'd0, cur.rwe});
        check(flags_out == cur.fl, cur.req, "flags", {27'd0, flags_out}, {27'd0, cur.fl});
        if (cur.qwe) check(quot == cur.q, cur.req, "quotient", quot, cur.q);
        if (cur.rwe) check(rem == cur.r, cur.req, "remainder", rem, cur.r);
      end
    end
  end

  function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                 input bit sg, input bit hf, input bit sd,
                                 input logic [4:0] fl, input string req);
    exp_t e;
    logic [31:0] d;
    d = !hf ? b : (sg ? {{16{b[15]}}, b[15:0]} : {16'd0, b[15:0]});
    e.req = req;
    e.due = 0;
    e.q = '0;
    e.r = '0;
    if (d == 0) begin
      e.qwe = 1'b0;
      e.rwe = 1'b0;
      e.fl  = fl | 5'b00100;
    end else begin
      if (sg && a == 32'h8000_0000 && d == 32'hFFFF_FFFF) begin
        e.q = a;
        e.r = 0;
      end else if (sg) begin
        e.q = $signed(a) / $signed(d);
        e.r = $signed(a) % $signed(d);
      end else begin
        e.q = a / d;
        e.r = a % d;
      end
      e.qwe = !sd;
      e.rwe = 1'b1;
      e.fl  = {fl[4], fl[3],
               (sg && a == 32'h8000_0000 && d == 32'hFFFF_FFFF),
               e.q[31], (e.q == 0)};
    end
    return e;
  endfunction

  task automatic issue(input logic [31:0] a, input logic [31:0] b,
                       input bit sg, input bit hf, input bit sd,
                       input logic [4:0] fl, input exp_t e);
    @(negedge clk);
    dividend  = a;
    divisor   = b;
    is_signed = sg;
    half_mode = hf;
    same_dest = sd;
    flags_in  = fl;
    start     = 1'b1;
    e.due     = cyc + 34;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic lit(input logic [31:0] a, input logic [31:0] b,
                     input bit sg, input bit hf, input bit sd, input logic [4:0] fl,
                     input logic [31:0] q, input logic [31:0] r,
                     input bit qwe, input bit rwe, input logic [4:0] flo,
                     input string req);
    exp_t e;
    e.q = q; e.r = r; e.qwe = qwe; e.rwe = rwe; e.fl = flo; e.req = req; e.due = 0;
    issue(a, b, sg, hf, sd, fl, e);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!done && !busy, "R11", "reset done/busy", {30'd0, done, busy}, 32'd0);
    check(!quot_we && !rem_we, "R11", "reset write enables", {30'd0, quot_we, rem_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // flags vector {SAT,CY,OV,S,Z}
    lit(45, 6, 1, 0, 0, 5'b00000, 7, 3, 1, 1, 5'b00000, "R1");
    lit(45, -6, 1, 0, 0, 5'b00000, -7, 3, 1, 1, 5'b00010, "R1_R2");
    lit(-45, 6, 1, 0, 0, 5'b00000, -7, -3, 1, 1, 5'b00010, "R1_R2");
    lit(-45, -6, 1, 0, 0, 5'b00000, 7, -3, 1, 1, 5'b00000, "R1");
    lit(16, 45, 1, 0, 0, 5'b00000, 0, 16, 1, 1, 5'b00001, "R2");
    lit(45, 6, 1, 0, 0, 5'b11100, 7, 3, 1, 1, 5'b11000, "R3");
    lit(45, 6, 0, 0, 0, 5'b10111, 7, 3, 1, 1, 5'b10000, "R3");
    lit(45, 0, 1, 0, 0, 5'b00000, 0, 0, 0, 0, 5'b00100, "R4");
    lit(45, 0, 1, 0, 0, 5'b11111, 0, 0, 0, 0, 5'b11111, "R4");
    lit(45, 32'h0001_0000, 0, 1, 0, 5'b01010, 0, 0, 0, 0, 5'b01110, "R4");
    lit(32'h8000_0000, -1, 1, 0, 0, 5'b00000, 32'h8000_0000, 0, 1, 1, 5'b00110, "R5");
    lit(32'h4000_0000, 4, 0, 0, 0, 5'b00000, 32'h1000_0000, 0, 1, 1, 5'b00000, "R6");
    lit(32'hFFFF_FFF0, 3, 0, 0, 0, 5'b00000, 32'h5555_5550, 0, 1, 1, 5'b00000, "R6");
    lit(-45, 32'h0000_FFFA, 1, 1, 0, 5'b00000, 7, -3, 1, 1, 5'b00000, "R7");
    lit(45, 32'h1234_FFFA, 1, 1, 0, 5'b00000, -7, 3, 1, 1, 5'b00010, "R7");
    lit(45, 32'h0001_0006, 0, 1, 0, 5'b00000, 7, 3, 1, 1, 5'b00000, "R8");
    lit(45, 32'h0000_FFFA, 0, 1, 0, 5'b00000, 0, 45, 1, 1, 5'b00001, "R8");
    lit(0, 45, 1, 0, 0, 5'b00100, 0, 0, 1, 1, 5'b00001, "R9");
    lit(45, 6, 1, 0, 1, 5'b00000, 0, 3, 0, 1, 5'b00000, "R10");

    for (int i = 0; i < 24; i++) begin
      logic [31:0] a, b;
      bit sg, hf, sd;
      logic [4:0] fl;
      a  = $urandom;
      b  = (i % 3 == 0) ? ($urandom % 100) : $urandom;
      sg = $urandom % 2;
      hf = $urandom % 2;
      sd = (i % 5 == 0);
      fl = $urandom;
      issue(a, b, sg, hf, sd, fl, model(a, b, sg, hf, sd, fl, "R1_R3_R6"));
    end

    // R12: second start while busy is ignored
    @(negedge clk);
    dividend = 100; divisor = 7; is_signed = 1'b0; half_mode = 1'b0;
    same_dest = 1'b0; flags_in = 5'b00000; start = 1'b1;
    cur = model(100, 7, 0, 0, 0, 5'b00000, "R12");
    cur.due = cyc + 34;
    sb.push_back(cur);
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    check(busy, "R12", "busy during run", {31'd0, busy}, 32'd1);
    dividend = 9; divisor = 0; same_dest = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    check(!busy, "R12", "idle after ignored start", {31'd0, busy}, 32'd0);

    lit(1000, 10, 1, 0, 0, 5'b00000, 100, 0, 1, 1, 5'b00000, "R11");

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule